// File: doc/BRIEF.md
# Memory Region Security Access Checker

This block sits between a bus and a memory and decides, for every access, whether the master that issued it may touch the addressed location. An access carries an address, a type (read, write or instruction fetch), a secure attribute and a privileged attribute. The address space holds one flash window and two SRAM windows. Software sets a small group of boundary registers that divide each window into protection regions. Each region belongs to one of five classes, and each class has fixed read, write and fetch rules.

A permitted access is forwarded to the memory one clock after the request. A denied access never reaches the memory. It returns an error response with zero read data, and the first denial since the last clear is latched into a sticky violation record. The boundary registers, the hide-area enable and the violation clear only respond to secure privileged configuration writes.

Top module: `mem_sec_gate`

## Requirements
- R1: Hide region: any access type is permitted only when the master is secure and privileged and the hide enable (config select 8, bit 0) is 1. With the enable at 0, every access to the region is denied.
- R2: Secure privileged region: read, write and fetch are permitted only when the master is both secure and privileged.
- R3: Write-restricted region: a write is permitted only for a secure privileged master. Read and fetch are permitted for every master.
- R4: Secure unprivileged region: all three types are permitted for secure masters at either privilege level and denied for non-secure masters.
- R5: Shared region: read and write are permitted for every master. Fetch is permitted only for non-secure masters.
- R6: Flash layout, with offset o taken from the flash base, tested in this order: o < secure start (select 0) is shared; o ≥ hide start (select 1) is hide; o < secure start + restricted length (select 2) is write-restricted; o < that sum + unprivileged length (select 3) is secure unprivileged; anything else is secure privileged.
- R7: SRAM layout, with offset o taken from the window base, for each SRAM window (selects 4/5 for the first, 6/7 for the second): o ≥ secure bound is shared; otherwise o + unprivileged length ≥ secure bound is secure unprivileged; otherwise secure privileged.
- R8: Addresses outside all three windows are denied, and so is type code 3. Type codes are 0 read, 1 write, 2 fetch.
- R9: A request at edge k produces a response at edge k+1. When the access is permitted, the memory strobe, address, write data and write enable are presented in that same cycle, and read or fetch data is passed from the memory. When it is denied, the error flag is raised, the memory strobe stays low and the read data is zero. Writes always return zero data.
- R10: The first denied access sets a violation flag and records its address, type and attributes. Later denials do not change the record while the flag is set.
- R11: A configuration write to select 9 clears the violation flag only when it is secure and privileged.
- R12: Configuration writes from a master that is not both secure and privileged are ignored.
- R13: After reset, every window is entirely secure privileged, the hide enable is 0, no violation is flagged and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request strobe |
| req_addr_i | input | AW | Access address |
| req_type_i | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_sec_i | input | 1 | Master is secure |
| req_priv_i | input | 1 | Master is privileged |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after request |
| rsp_err_o | output | 1 | Access was denied |
| rsp_rdata_o | output | DW | Read or fetch data, zero if denied |
| mem_valid_o | output | 1 | Forwarded access strobe |
| mem_we_o | output | 1 | Forwarded write enable |
| mem_addr_o | output | AW | Forwarded address |
| mem_wdata_o | output | DW | Forwarded write data |
| mem_rdata_i | input | DW | Memory read data, same cycle as strobe |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 4 | Configuration register select |
| cfg_wdata_i | input | AW | Configuration write value |
| cfg_sec_i | input | 1 | Configuration writer is secure |
| cfg_priv_i | input | 1 | Configuration writer is privileged |
| viol_o | output | 1 | Sticky violation flag |
| viol_addr_o | output | AW | Address of the first denied access |
| viol_type_o | output | 2 | Type of the first denied access |
| viol_sec_o | output | 1 | Secure attribute of the first denied access |
| viol_priv_o | output | 1 | Privileged attribute of the first denied access |

## Verification
The bench builds the block with an 8-bit address and 8-bit data: a 64-byte flash at 0x00 and two 32-byte SRAM windows at 0x40 and 0x60, with the upper half unmapped. At these sizes every address can be driven with every type and every secure/privileged pairing under several boundary settings. These settings include the reset layout, hide enabled and disabled, watermarks larger than the bound, and an SRAM window that is entirely shared. As a result, every region edge, every rule cell and the unmapped space are visited.

// File: rtl/msg_pkg.sv
package msg_pkg;
  typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_FX = 2'd2, ACC_RSV = 2'd3} acc_e;
  typedef enum logic [2:0] {CLS_NONE, CLS_HIDE, CLS_SP, CLS_SPW, CLS_SU, CLS_NSU} cls_e;

  localparam logic [3:0] SEL_F_SEC   = 4'd0;
  localparam logic [3:0] SEL_F_HIDE  = 4'd1;
  localparam logic [3:0] SEL_F_WRO   = 4'd2;
  localparam logic [3:0] SEL_F_UPW   = 4'd3;
  localparam logic [3:0] SEL_S1_SEC  = 4'd4;
  localparam logic [3:0] SEL_S1_UPW  = 4'd5;
  localparam logic [3:0] SEL_S2_SEC  = 4'd6;
  localparam logic [3:0] SEL_S2_UPW  = 4'd7;
  localparam logic [3:0] SEL_HIDE_EN = 4'd8;
  localparam logic [3:0] SEL_CLR     = 4'd9;
endpackage

// File: rtl/msg_cfg_regs.sv
module msg_cfg_regs
  import msg_pkg::*;
#(
  parameter int AW         = 16,
  parameter int FLASH_SIZE = 'h4000,
  parameter int SRAM1_SIZE = 'h2000,
  parameter int SRAM2_SIZE = 'h2000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [3:0]           sel_i,
  input  logic [AW-1:0]        wdata_i,
  input  logic                 sec_i,
  input  logic                 priv_i,
  output logic [AW-1:0]        f_sec_o,
  output logic [AW-1:0]        f_hide_o,
  output logic [AW-1:0]        f_wro_o,
  output logic [AW-1:0]        f_upw_o,
  output logic [1:0][AW-1:0]   s_sec_o,
  output logic [1:0][AW-1:0]   s_upw_o,
  output logic                 hide_en_o,
  output logic                 clr_o
);
  logic wr_ok;
  assign wr_ok = we_i & sec_i & priv_i;
  assign clr_o = wr_ok && (sel_i == SEL_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_sec_o    <= '0;
      f_hide_o   <= AW'(FLASH_SIZE);
      f_wro_o    <= '0;
      f_upw_o    <= '0;
      s_sec_o[0] <= AW'(SRAM1_SIZE);
      s_sec_o[1] <= AW'(SRAM2_SIZE);
      s_upw_o    <= '0;
      hide_en_o  <= 1'b0;
    end else if (wr_ok) begin
      case (sel_i)
        SEL_F_SEC:   f_sec_o    <= wdata_i;
        SEL_F_HIDE:  f_hide_o   <= wdata_i;
        SEL_F_WRO:   f_wro_o    <= wdata_i;
        SEL_F_UPW:   f_upw_o    <= wdata_i;
        SEL_S1_SEC:  s_sec_o[0] <= wdata_i;
        SEL_S1_UPW:  s_upw_o[0] <= wdata_i;
        SEL_S2_SEC:  s_sec_o[1] <= wdata_i;
        SEL_S2_UPW:  s_upw_o[1] <= wdata_i;
        SEL_HIDE_EN: hide_en_o  <= wdata_i[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msg_region_decode.sv
module msg_region_decode
  import msg_pkg::*;
#(
  parameter int AW         = 16,
  parameter int FLASH_BASE = 'h0000,
  parameter int FLASH_SIZE = 'h4000,
  parameter int SRAM1_BASE = 'h4000,
  parameter int SRAM1_SIZE = 'h2000,
  parameter int SRAM2_BASE = 'h6000,
  parameter int SRAM2_SIZE = 'h2000
) (
  input  logic [AW-1:0]      addr_i,
  input  logic [AW-1:0]      f_sec_i,
  input  logic [AW-1:0]      f_hide_i,
  input  logic [AW-1:0]      f_wro_i,
  input  logic [AW-1:0]      f_upw_i,
  input  logic [1:0][AW-1:0] s_sec_i,
  input  logic [1:0][AW-1:0] s_upw_i,
  output cls_e               cls_o
);
  // two spare bits keep window offsets and boundary sums free of wrap
  localparam int W = AW + 2;

  logic [W-1:0] a, fo, f_spw_end, f_su_end;
  logic         f_in;
  cls_e         f_cls;

  assign a         = W'(addr_i);
  assign fo        = a - W'(FLASH_BASE);
  assign f_in      = fo < W'(FLASH_SIZE);
  assign f_spw_end = W'(f_sec_i) + W'(f_wro_i);
  assign f_su_end  = f_spw_end + W'(f_upw_i);

  always_comb begin
    if (fo < W'(f_sec_i))        f_cls = CLS_NSU;
    else if (fo >= W'(f_hide_i)) f_cls = CLS_HIDE;
    else if (fo < f_spw_end)     f_cls = CLS_SPW;
    else if (fo < f_su_end)      f_cls = CLS_SU;
    else                         f_cls = CLS_SP;
  end

  logic [1:0] s_in;
  for (genvar j = 0; j < 2; j++) begin : g_sram
    localparam int B = (j == 0) ? SRAM1_BASE : SRAM2_BASE;
    localparam int S = (j == 0) ? SRAM1_SIZE : SRAM2_SIZE;
    logic [W-1:0] off;
    cls_e         cls;
    assign off     = a - W'(B);
    assign s_in[j] = off < W'(S);
    always_comb begin
      if (off >= W'(s_sec_i[j]))                    cls = CLS_NSU;
      else if (off + W'(s_upw_i[j]) >= W'(s_sec_i[j])) cls = CLS_SU;
      else                                          cls = CLS_SP;
    end
  end

  always_comb begin
    if (f_in)         cls_o = f_cls;
    else if (s_in[0]) cls_o = g_sram[0].cls;
    else if (s_in[1]) cls_o = g_sram[1].cls;
    else              cls_o = CLS_NONE;
  end
endmodule

// File: rtl/msg_rule.sv
module msg_rule
  import msg_pkg::*;
(
  input  cls_e       cls_i,
  input  logic [1:0] type_i,
  input  logic       sec_i,
  input  logic       priv_i,
  input  logic       hide_en_i,
  output logic       permit_o
);
  logic sp, is_wr, is_fx;
  assign sp    = sec_i & priv_i;
  assign is_wr = type_i == ACC_WR;
  assign is_fx = type_i == ACC_FX;

  always_comb begin
    if (type_i == ACC_RSV) permit_o = 1'b0;
    else begin
      case (cls_i)
        CLS_HIDE: permit_o = sp & hide_en_i;
        CLS_SP:   permit_o = sp;
        CLS_SPW:  permit_o = is_wr ? sp : 1'b1;
        CLS_SU:   permit_o = sec_i;
        CLS_NSU:  permit_o = is_fx ? ~sec_i : 1'b1;
        default:  permit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mem_sec_gate.sv
module mem_sec_gate
  import msg_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int FLASH_BASE = 'h0000,
  parameter int FLASH_SIZE = 'h4000,
  parameter int SRAM1_BASE = 'h4000,
  parameter int SRAM1_SIZE = 'h2000,
  parameter int SRAM2_BASE = 'h6000,
  parameter int SRAM2_SIZE = 'h2000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_type_i,
  input  logic          req_sec_i,
  input  logic          req_priv_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          cfg_we_i,
  input  logic [3:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          cfg_sec_i,
  input  logic          cfg_priv_i,
  output logic          viol_o,
  output logic [AW-1:0] viol_addr_o,
  output logic [1:0]    viol_type_o,
  output logic          viol_sec_o,
  output logic          viol_priv_o
);
  logic [AW-1:0]      f_sec, f_hide, f_wro, f_upw;
  logic [1:0][AW-1:0] s_sec, s_upw;
  logic               hide_en, clr;
  cls_e               cls;
  logic               permit;

  msg_cfg_regs #(
    .AW(AW), .FLASH_SIZE(FLASH_SIZE), .SRAM1_SIZE(SRAM1_SIZE), .SRAM2_SIZE(SRAM2_SIZE)
  ) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .sec_i(cfg_sec_i), .priv_i(cfg_priv_i),
    .f_sec_o(f_sec), .f_hide_o(f_hide), .f_wro_o(f_wro), .f_upw_o(f_upw),
    .s_sec_o(s_sec), .s_upw_o(s_upw), .hide_en_o(hide_en), .clr_o(clr)
  );

  msg_region_decode #(
    .AW(AW), .FLASH_BASE(FLASH_BASE), .FLASH_SIZE(FLASH_SIZE),
    .SRAM1_BASE(SRAM1_BASE), .SRAM1_SIZE(SRAM1_SIZE),
    .SRAM2_BASE(SRAM2_BASE), .SRAM2_SIZE(SRAM2_SIZE)
  ) i_dec (
    .addr_i(req_addr_i), .f_sec_i(f_sec), .f_hide_i(f_hide), .f_wro_i(f_wro),
    .f_upw_i(f_upw), .s_sec_i(s_sec), .s_upw_i(s_upw), .cls_o(cls)
  );

  msg_rule i_rule (
    .cls_i(cls), .type_i(req_type_i), .sec_i(req_sec_i), .priv_i(req_priv_i),
    .hide_en_i(hide_en), .permit_o(permit)
  );

  // decision stage
  logic          st_valid, st_permit;
  logic [AW-1:0] st_addr;
  logic [1:0]    st_type;
  logic [DW-1:0] st_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_valid  <= 1'b0;
      st_permit <= 1'b0;
      st_addr   <= '0;
      st_type   <= '0;
      st_wdata  <= '0;
    end else begin
      st_valid <= req_valid_i;
      if (req_valid_i) begin
        st_permit <= permit;
        st_addr   <= req_addr_i;
        st_type   <= req_type_i;
        st_wdata  <= req_wdata_i;
      end
    end
  end

  assign rsp_valid_o = st_valid;
  assign rsp_err_o   = st_valid & ~st_permit;
  assign mem_valid_o = st_valid & st_permit;
  assign mem_we_o    = mem_valid_o && (st_type == ACC_WR);
  assign mem_addr_o  = st_addr;
  assign mem_wdata_o = st_wdata;
  assign rsp_rdata_o = (mem_valid_o && st_type != ACC_WR) ? mem_rdata_i : '0;

  // sticky record of first denial; a denial in the clearing cycle is kept
  logic deny_now;
  assign deny_now = req_valid_i & ~permit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o      <= 1'b0;
      viol_addr_o <= '0;
      viol_type_o <= '0;
      viol_sec_o  <= 1'b0;
      viol_priv_o <= 1'b0;
    end else if (deny_now && (!viol_o || clr)) begin
      viol_o      <= 1'b1;
      viol_addr_o <= req_addr_i;
      viol_type_o <= req_type_i;
      viol_sec_o  <= req_sec_i;
      viol_priv_o <= req_priv_i;
    end else if (clr) begin
      viol_o <= 1'b0;
    end
  end
endmodule

// File: rtl/msg_checker.sv
module msg_checker
  import msg_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [1:0]    req_type_i,
  input logic          rsp_valid_o,
  input logic          rsp_err_o,
  input logic [DW-1:0] rsp_rdata_o,
  input logic          mem_valid_o,
  input logic          cfg_we_i,
  input logic [3:0]    cfg_sel_i,
  input logic          cfg_sec_i,
  input logic          cfg_priv_i,
  input logic          viol_o,
  input logic [AW-1:0] viol_addr_o,
  input logic [1:0]    viol_type_o
);
  logic clr_req;
  assign clr_req = cfg_we_i && cfg_sel_i == SEL_CLR && cfg_sec_i && cfg_priv_i;

  a_r9_rsp_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r9_no_rsp_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r9_err_blocks_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (!mem_valid_o && rsp_rdata_o == '0));
  a_r8_reserved_denied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_type_i == 2'd3) |=> rsp_err_o);
  a_r10_err_flags_viol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> viol_o);
  a_r10_record_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && !clr_req) |=> (viol_o && $stable(viol_addr_o) && $stable(viol_type_o)));
endmodule

bind mem_sec_gate msg_checker #(.AW(AW), .DW(DW)) i_msg_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_type_i(req_type_i),
  .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o),
  .mem_valid_o(mem_valid_o), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
  .cfg_sec_i(cfg_sec_i), .cfg_priv_i(cfg_priv_i), .viol_o(viol_o),
  .viol_addr_o(viol_addr_o), .viol_type_o(viol_type_o)
);

// File: tb/test_mem_sec_gate.sv
module test_mem_sec_gate;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [1:0]    req_type_i = '0;
  logic          req_sec_i = 1'b0, req_priv_i = 1'b0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          rsp_valid_o, rsp_err_o, mem_valid_o, mem_we_o;
  logic [DW-1:0] rsp_rdata_o, mem_wdata_o, mem_rdata_i;
  logic [AW-1:0] mem_addr_o;
  logic          cfg_we_i = 1'b0;
  logic [3:0]    cfg_sel_i = '0;
  logic [AW-1:0] cfg_wdata_i = '0;
  logic          cfg_sec_i = 1'b0, cfg_priv_i = 1'b0;
  logic          viol_o, viol_sec_o, viol_priv_o;
  logic [AW-1:0] viol_addr_o;
  logic [1:0]    viol_type_o;

  always #2.5 clk = ~clk;

  assign mem_rdata_i = {mem_addr_o[6:0], 1'b1};

  mem_sec_gate #(
    .AW(AW), .DW(DW), .FLASH_BASE('h00), .FLASH_SIZE('h40),
    .SRAM1_BASE('h40), .SRAM1_SIZE('h20), .SRAM2_BASE('h60), .SRAM2_SIZE('h20)
  ) i_mem_sec_gate (.clk_i(clk), .*);

  int errors = 0, checks = 0;
  int m_fsec, m_fhide, m_fwro, m_fupw, m_hen;
  int m_ssec [2];
  int m_supw [2];
  bit have_first;
  int f_addr, f_type, f_sec, f_priv;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // 0 none, 1 hide, 2 sec priv, 3 write-restricted, 4 sec unpriv, 5 shared
  function automatic int cls_of(int a);
    if (a < 64) begin
      if (a < m_fsec) return 5;
      if (a >= m_fhide) return 1;
      if (a < m_fsec + m_fwro) return 3;
      if (a < m_fsec + m_fwro + m_fupw) return 4;
      return 2;
    end
    if (a < 128) begin
      int j = (a - 64) / 32;
      int o = (a - 64) % 32;
      if (o >= m_ssec[j]) return 5;
      if (o + m_supw[j] >= m_ssec[j]) return 4;
      return 2;
    end
    return 0;
  endfunction

  function automatic bit perm_of(int c, int t, bit s, bit p);
    if (t == 3) return 0;
    case (c)
      1: return s && p && m_hen != 0;
      2: return s && p;
      3: return (t == 1) ? (s && p) : 1'b1;
      4: return s;
      5: return (t == 2) ? !s : 1'b1;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a, int c, int t);
    string w, r;
    w = (a < 64) ? "R6" : (a < 128) ? "R7" : "R8";
    case (c)
      1: r = "R1";
      2: r = "R2";
      3: r = "R3";
      4: r = "R4";
      5: r = "R5";
      default: r = "R8";
    endcase
    if (t == 3) r = "R8";
    return {w, " ", r, " R9 R10"};
  endfunction

  task automatic cfg_wr(logic [3:0] sel, int val, bit s, bit p);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = AW'(val);
    cfg_sec_i = s; cfg_priv_i = p;
    @(negedge clk);
    cfg_we_i = 1'b0;
    if (s && p) begin
      case (sel)
        4'd0: m_fsec = val;
        4'd1: m_fhide = val;
        4'd2: m_fwro = val;
        4'd3: m_fupw = val;
        4'd4: m_ssec[0] = val;
        4'd5: m_supw[0] = val;
        4'd6: m_ssec[1] = val;
        4'd7: m_supw[1] = val;
        4'd8: m_hen = val & 1;
        default: ;
      endcase
    end
  endtask

  // called at a negedge; returns at the next negedge with the response checked
  task automatic access(int a, int t, bit s, bit p, string extra);
    int  c = cls_of(a);
    bit  pm = perm_of(c, t, s, p);
    logic [11:0] act, exp;
    logic [7:0]  ed;
    req_valid_i = 1'b1; req_addr_i = AW'(a); req_type_i = 2'(t);
    req_sec_i = s; req_priv_i = p; req_wdata_i = DW'(a ^ 'h3C);
    if (!pm && !have_first) begin
      have_first = 1; f_addr = a; f_type = t; f_sec = s; f_priv = p;
    end
    @(negedge clk);
    req_valid_i = 1'b0;
    ed  = (pm && t != 1) ? {a[6:0], 1'b1} : 8'h00;
    exp = {1'b1, !pm, pm, pm && t == 1, ed};
    act = {rsp_valid_o, rsp_err_o, mem_valid_o, mem_we_o, rsp_rdata_o};
    if (pm && (mem_addr_o != AW'(a) || (t == 1 && mem_wdata_o != DW'(a ^ 'h3C))))
      act[11] = 1'b0;
    chk(act == exp, {extra, tag_of(a, c, t)}, int'(act), int'(exp));
  endtask

  task automatic sweep(string extra);
    cfg_wr(4'd9, 0, 1, 1);
    chk(viol_o == 1'b0, "R11 secure clear", viol_o, 0);
    have_first = 0;
    for (int a = 0; a < 256; a++)
      for (int t = 0; t < 4; t++)
        for (int sp = 0; sp < 4; sp++)
          access(a, t, sp[1], sp[0], extra);
    @(negedge clk);
    chk(viol_o == have_first, "R10 flag", viol_o, have_first);
    if (have_first)
      chk(viol_addr_o == AW'(f_addr) && viol_type_o == 2'(f_type) &&
          viol_sec_o == f_sec && viol_priv_o == f_priv, "R10 first record",
          {viol_addr_o, viol_type_o, viol_sec_o, viol_priv_o},
          {f_addr[7:0], f_type[1:0], f_sec[0], f_priv[0]});
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_fsec = 0; m_fhide = 64; m_fwro = 0; m_fupw = 0; m_hen = 0;
    m_ssec[0] = 32; m_ssec[1] = 32; m_supw[0] = 0; m_supw[1] = 0;
    repeat (3) @(negedge clk);
    chk(rsp_valid_o == 0 && mem_valid_o == 0 && viol_o == 0, "R13 reset outputs",
        {rsp_valid_o, mem_valid_o, viol_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // reset layout: every window secure privileged
    sweep("R13 ");

    // mixed layout with hide enabled
    cfg_wr(4'd0, 8, 1, 1);  cfg_wr(4'd2, 8, 1, 1);  cfg_wr(4'd3, 8, 1, 1);
    cfg_wr(4'd1, 48, 1, 1); cfg_wr(4'd8, 1, 1, 1);
    cfg_wr(4'd4, 20, 1, 1); cfg_wr(4'd5, 6, 1, 1);
    cfg_wr(4'd6, 10, 1, 1); cfg_wr(4'd7, 10, 1, 1);
    sweep("");

    // ignored non-secure / unprivileged writes
    cfg_wr(4'd4, 30, 0, 1);
    cfg_wr(4'd8, 0, 1, 0);
    access('h40 + 25, 2, 0, 0, "R12 ");
    access('h3A, 0, 1, 1, "R12 ");
    // non-secure clear must not drop the flag
    chk(viol_o == 1'b1, "R11 flag before clear", viol_o, 1);
    cfg_wr(4'd9, 0, 0, 1);
    chk(viol_o == 1'b1, "R11 non-secure clear ignored", viol_o, 1);
    cfg_wr(4'd9, 0, 1, 0);
    chk(viol_o == 1'b1, "R11 unprivileged clear ignored", viol_o, 1);

    // hide disabled
    cfg_wr(4'd8, 0, 1, 1);
    sweep("R1 ");

    // edge layout: watermark beyond bound, fully shared SRAM2
    cfg_wr(4'd0, 0, 1, 1);  cfg_wr(4'd2, 0, 1, 1);  cfg_wr(4'd3, 64, 1, 1);
    cfg_wr(4'd1, 60, 1, 1); cfg_wr(4'd8, 1, 1, 1);
    cfg_wr(4'd4, 5, 1, 1);  cfg_wr(4'd5, 31, 1, 1);
    cfg_wr(4'd6, 0, 1, 1);  cfg_wr(4'd7, 0, 1, 1);
    sweep("");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule